// File: doc/BRIEF.md
# Ones Complement End-Around Adder

A purely combinational adder and subtractor for signed words held in ones complement form. The two operands are first summed as plain unsigned words. A carry that leaves the top bit is then folded back into the bottom bit, and that second addition is allowed to ripple. To subtract, the second operand is bitwise inverted before the sum, because inverting every bit is how a ones complement value is negated.

The block has three outputs: the result word, an overflow flag and a flag for the negative-zero pattern. A word's value is its lower bits weighted as usual, minus (2^(WIDTH-1)-1) when the top bit is set. This gives the symmetric range -(2^(WIDTH-1)-1) to +(2^(WIDTH-1)-1), which has two encodings of zero: all zeros and all ones. The block passes an all-ones result through unchanged and only flags it. Any caller that needs a single zero must fold the two zeros itself.

Top module: `ones_comp_eac_adder`

## Requirements
- R1: With `opSub` = 0, `sumOut` equals the low WIDTH bits of opA + opB (unsigned), plus 1 when that unsigned sum reaches 2^WIDTH.
- R2: With `opSub` = 1, the block behaves as in R1 with opB replaced by its bitwise inverse, so the result represents opA minus opB.
- R3: `overflow` is 1 exactly when opA and the effective second operand have the same top bit and the final `sumOut` has a different top bit. The flag is judged after the end-around carry.
- R4: `negZero` is 1 exactly when every bit of `sumOut` is 1.
- R5: When the effective second operand is the bitwise inverse of opA, `sumOut` is all ones. The negative-zero pattern is not rewritten to all zeros.
- R6: When `overflow` is 0, the signed value of `sumOut` equals the integer sum (or difference) of the operands' signed values. Both zero encodings decode to 0.
- R7: Adding the end-around carry back in never produces a further carry out of the top bit, so the final result always fits in WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand, ones complement |
| opB | input | WIDTH | Second operand, ones complement |
| opSub | input | 1 | 0 = add, 1 = subtract opB from opA |
| sumOut | output | WIDTH | Ones complement result after the end-around carry |
| overflow | output | 1 | Result is outside the representable range |
| negZero | output | 1 | Result is the all-ones (negative zero) pattern |

## Verification
The in-RTL checks assume that all inputs carry known values, and they skip evaluation while any input is unknown. The bench sets every input at once, shortly after a clock edge, and holds it steady until the sample point, so the checks only see settled combinational values. Stimulus covers every operand pair in both modes at the default width, and this includes every mix of the two zero encodings and both ends of the range.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic {
    OC_OP_ADD = 1'b0,
    OC_OP_SUB = 1'b1
  } ocOp_e;

  typedef struct packed {
    logic invertB;
    logic wrapCarry;
  } ocStrobe_t;

endpackage

// File: rtl/oc_control.sv
module oc_control
  import oc_pkg::*;
(
  input  logic      opSub,
  output ocStrobe_t strobe
);

  ocOp_e opKind;

  always_comb begin
    opKind = ocOp_e'(opSub);
    strobe = '0;
    strobe.wrapCarry = 1'b1;
    unique case (opKind)
      OC_OP_ADD: strobe.invertB = 1'b0;
      OC_OP_SUB: strobe.invertB = 1'b1;
      default:   strobe.invertB = 1'b0;
    endcase
  end

endmodule

// File: rtl/oc_flags.sv
module oc_flags #(
  parameter int WIDTH = 8
) (
  input  logic             aSign,
  input  logic             bSign,
  input  logic [WIDTH-1:0] result,
  output logic             overflow,
  output logic             negZero
);

  localparam int TOP = WIDTH - 1;

  logic sameSign;
  logic resSign;

  always_comb begin
    sameSign = ~(aSign ^ bSign);
    resSign  = result[TOP];
    overflow = sameSign & (resSign ^ aSign);
    negZero  = &result;
  end

  // R4: the negative-zero flag implies the result's top bit is set
  always_comb begin
    if (!$isunknown(result))
      p_negzero_sign_r4: assert (!negZero || result[TOP])
        else $error("negZero raised with a clear top bit");
  end

  // R3: overflow only when the two operands share a sign
  always_comb begin
    if (!$isunknown({aSign, bSign, result}))
      p_overflow_signs_r3: assert (!overflow || (aSign == bSign))
        else $error("overflow raised for operands of opposite sign");
  end

endmodule

// File: rtl/oc_datapath.sv
module oc_datapath
  import oc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ocStrobe_t        strobe,
  output logic [WIDTH-1:0] sumOut,
  output logic             overflow,
  output logic             negZero
);

  localparam int TOP = WIDTH - 1;
  localparam int EXT = WIDTH + 1;

  logic [WIDTH-1:0] bEff;
  logic [EXT-1:0]   firstSum;
  logic             wrapIn;
  logic [EXT-1:0]   secondSum;
  logic             reCarry;

  always_comb begin
    bEff      = strobe.invertB ? ~opB : opB;
    firstSum  = {1'b0, opA} + {1'b0, bEff};
    wrapIn    = strobe.wrapCarry & firstSum[WIDTH];
    secondSum = {1'b0, firstSum[TOP:0]} + {{WIDTH{1'b0}}, wrapIn};
    sumOut    = secondSum[TOP:0];
    reCarry   = secondSum[WIDTH];
  end

  oc_flags #(.WIDTH(WIDTH)) u_flags (
    .aSign   (opA[TOP]),
    .bSign   (bEff[TOP]),
    .result  (sumOut),
    .overflow(overflow),
    .negZero (negZero)
  );

  // R7: the fold-back addition never carries out again
  always_comb begin
    if (!$isunknown({opA, opB, strobe}))
      p_no_second_carry_r7: assert (!reCarry)
        else $error("end-around addition carried out of the top bit");
  end

  // R5: an operand plus its own inverse gives the all-ones word
  always_comb begin
    if (!$isunknown({opA, opB, strobe}))
      p_inverse_allones_r5: assert ((bEff != ~opA) || (&sumOut))
        else $error("x + ~x did not give negative zero");
  end

endmodule

// File: rtl/ones_comp_eac_adder.sv
module ones_comp_eac_adder
  import oc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             opSub,
  output logic [WIDTH-1:0] sumOut,
  output logic             overflow,
  output logic             negZero
);

  ocStrobe_t strobe;

  oc_control u_control (
    .opSub (opSub),
    .strobe(strobe)
  );

  oc_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .sumOut  (sumOut),
    .overflow(overflow),
    .negZero (negZero)
  );

endmodule

// File: tb/ones_comp_eac_adder_bench.sv
`timescale 1ns/1ps
module ones_comp_eac_adder_bench;

  localparam int N = 8;
  localparam int unsigned MASK = (1 << N) - 1;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] opA = '0;
  logic [N-1:0] opB = '0;
  logic opSub = 1'b0;
  logic [N-1:0] sumOut;
  logic overflow;
  logic negZero;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ones_comp_eac_adder #(.WIDTH(N)) u_ones_comp_eac_adder (
    .opA(opA), .opB(opB), .opSub(opSub),
    .sumOut(sumOut), .overflow(overflow), .negZero(negZero)
  );

  function automatic int decode(int unsigned v);
    if (((v >> (N - 1)) & 1) != 0) return -int'((~v) & MASK);
    return int'(v);
  endfunction

  task automatic expect_eq(string req, int unsigned act, int unsigned exp, int op, int a, int b);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%0h b=%0h actual=%0h expected=%0h", req, op, a, b, act, exp);
    end
  endtask

  task automatic check_vector(int op, int a, int b);
    int unsigned be, s, r, c, r2;
    int sa, sb, sr;
    bit ov;
    be = (op != 0) ? ((~b) & MASK) : b;
    s  = a + be;
    r  = s & MASK;
    c  = s >> N;
    r2 = r + c;
    // R7: the model result must still fit, and the port must match it
    checks++;
    if (r2 > MASK) begin
      errors++;
      $display("FAIL R7 second carry actual=%0h expected<=%0h", r2, MASK);
    end
    expect_eq((op != 0) ? "R2" : "R1", sumOut, r2 & MASK, op, a, b);
    sa = (a >> (N - 1)) & 1;
    sb = (be >> (N - 1)) & 1;
    sr = (r2 >> (N - 1)) & 1;
    ov = (sa == sb) && (sr != sa);
    expect_eq("R3", overflow, ov, op, a, b);
    expect_eq("R4", negZero, (r2 & MASK) == MASK, op, a, b);
    if (be == ((~a) & MASK)) expect_eq("R5", sumOut, MASK, op, a, b);
    if (!ov) begin
      int want = (op != 0) ? decode(a) - decode(b) : decode(a) + decode(b);
      checks++;
      if (decode(sumOut) != want) begin
        errors++;
        $display("FAIL R6 op=%0d a=%0h b=%0h actual=%0d expected=%0d",
                 op, a, b, decode(sumOut), want);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state: zero plus zero is positive zero, no flags (R1, R4)
    expect_eq("R1", sumOut, 0, 0, 0, 0);
    expect_eq("R4", negZero, 0, 0, 0, 0);
    for (int op = 0; op < 2; op++) begin
      for (int a = 0; a <= int'(MASK); a++) begin
        for (int b = 0; b <= int'(MASK); b++) begin
          @(posedge clk);
          #1;
          opA = a[N-1:0];
          opB = b[N-1:0];
          opSub = op[0];
          @(negedge clk);
          check_vector(op, a, b);
        end
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule